// File: doc/BRIEF.md
# RGB to four-color key quantizer

This block turns a stream of 24-bit RGB pixels (8 bits per channel) into a stream of 2-bit native color codes for a black/white/yellow/red panel. Both sides use valid/ready handshakes. The block first asks whether a pixel is close to gray. If so, it picks black or white by luminance. If not, it decides by which of the three channels are strongly lit.

The pipeline has two register stages. Stage 1 registers the channel spread (largest minus smallest), the 10-bit channel sum and the raw channels. Stage 2 registers the chosen code. A small occupancy state machine tracks which stages hold a pixel. It has four states:

- EMPTY: no stage holds a pixel.
- HEAD: only stage 1 holds a pixel.
- TAIL: only stage 2 holds a pixel.
- BOTH: both stages hold a pixel.

On every advance, the next state is formed from the input valid (new stage 1) and the old stage-1 occupancy (new stage 2). When the pipeline does not advance, the state holds. The pipeline stalls as one unit. The four output code values are parameters.

Top module: `rgb4_quant`

## Requirements
- R1: A pixel whose largest channel minus smallest channel is below 50 is gray. A gray pixel gives white when r+g+b exceeds 382 and black otherwise, with the sum computed to 10 bits.
- R2: For a non-gray pixel, a channel is lit only when its value is strictly above 128 (128 is unlit, 129 is lit).
- R3: For a non-gray pixel with red lit and blue unlit, the output is yellow when green is lit and red when green is unlit.
- R4: A non-gray pixel with both red and blue lit gives white.
- R5: A non-gray pixel with red unlit gives white when green and blue are both lit, and black otherwise.
- R6: With default parameters the codes are black=2'b00, white=2'b01, yellow=2'b10, red=2'b11.
- R7: With the pipeline empty and out_ready high, a pixel presented with in_valid in cycle n appears with out_valid in cycle n+2 and not before.
- R8: in_ready is high exactly when out_valid is low or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_code hold their values into the next cycle.
- R9: Every accepted pixel yields exactly one output code, in acceptance order. Backpressure causes no drop and no duplicate.
- R10: During reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| out_valid | output | 1 | Output code valid |
| out_ready | input | 1 | Consumer accepts the code |
| out_code | output | 2 | Native color code |

## Verification
The hardest case to reach from the ports is a full pipeline held by backpressure for several cycles, with new pixels waiting at the input. Here order and uniqueness are most at risk. The bench reaches it by pulling out_ready low at random while a producer pushes back-to-back pixels. It also checks that each held code stays stable while stalled. Thresholds are probed with every combination of the channel values 0, 49, 50, 128, 129 and 255, and with gray sums of exactly 382 and 383.

// File: rtl/rgb4_pkg.sv
`timescale 1ns/1ps
package rgb4_pkg;
    // Occupancy of the two pipeline stages, encoded {stage1, stage2}
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'b00,
        OCC_TAIL  = 2'b01,
        OCC_HEAD  = 2'b10,
        OCC_BOTH  = 2'b11
    } occ_e;
endpackage

// File: rtl/rgb4_flow.sv
`timescale 1ns/1ps
module rgb4_flow
    import rgb4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv,
    output logic s1_v,
    output logic s2_v
);
    occ_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // next state: an advance shifts stage 1 into stage 2 and loads the input
    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                OCC_EMPTY: state_d = in_valid ? OCC_HEAD : OCC_EMPTY;
                OCC_TAIL:  state_d = in_valid ? OCC_HEAD : OCC_EMPTY;
                OCC_HEAD:  state_d = in_valid ? OCC_BOTH : OCC_TAIL;
                OCC_BOTH:  state_d = in_valid ? OCC_BOTH : OCC_TAIL;
                default:   state_d = OCC_EMPTY;
            endcase
        end
    end

    // outputs
    always_comb begin
        s1_v = 1'b0;
        s2_v = 1'b0;
        unique case (state_q)
            OCC_EMPTY: begin s1_v = 1'b0; s2_v = 1'b0; end
            OCC_TAIL:  begin s1_v = 1'b0; s2_v = 1'b1; end
            OCC_HEAD:  begin s1_v = 1'b1; s2_v = 1'b0; end
            OCC_BOTH:  begin s1_v = 1'b1; s2_v = 1'b1; end
            default:   begin s1_v = 1'b0; s2_v = 1'b0; end
        endcase
        adv = !s2_v || out_ready;
    end

    // R7
    // a stage-1 pixel moves into stage 2 on an advance
    shift_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v) |=> s2_v);

    // R9
    // an empty stage 1 on an advance leaves stage 2 empty
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !s1_v) |=> !s2_v);
endmodule

// File: rtl/rgb4_span.sv
`timescale 1ns/1ps
module rgb4_span #(
    parameter int CW   = 8,
    parameter int SUMW = CW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [CW-1:0]   r,
    input  logic [CW-1:0]   g,
    input  logic [CW-1:0]   b,
    output logic [CW-1:0]   r_q,
    output logic [CW-1:0]   g_q,
    output logic [CW-1:0]   b_q,
    output logic [CW-1:0]   spread_q,
    output logic [SUMW-1:0] sum_q
);
    logic [CW-1:0]   hi, lo, hi_rg, lo_rg;
    logic [SUMW-1:0] sum_d;

    always_comb begin
        hi_rg = (r > g) ? r : g;
        lo_rg = (r < g) ? r : g;
        hi    = (hi_rg > b) ? hi_rg : b;
        lo    = (lo_rg < b) ? lo_rg : b;
        sum_d = SUMW'(r) + SUMW'(g) + SUMW'(b);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            g_q      <= '0;
            b_q      <= '0;
            spread_q <= '0;
            sum_q    <= '0;
        end else if (adv) begin
            r_q      <= r;
            g_q      <= g;
            b_q      <= b;
            spread_q <= hi - lo;
            sum_q    <= sum_d;
        end
    end
endmodule

// File: rtl/rgb4_classify.sv
`timescale 1ns/1ps
module rgb4_classify #(
    parameter int         CW         = 8,
    parameter int         SUMW       = CW + 2,
    parameter int         SPREAD_LIM = 50,
    parameter int         LUMA_SPLIT = 382,
    parameter int         ON_LEVEL   = 128,
    parameter logic [1:0] CODE_BLACK = 2'b00,
    parameter logic [1:0] CODE_WHITE = 2'b01,
    parameter logic [1:0] CODE_YEL   = 2'b10,
    parameter logic [1:0] CODE_RED   = 2'b11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic [CW-1:0]   r_q,
    input  logic [CW-1:0]   g_q,
    input  logic [CW-1:0]   b_q,
    input  logic [CW-1:0]   spread_q,
    input  logic [SUMW-1:0] sum_q,
    output logic [1:0]      code_q
);
    localparam logic [CW-1:0]   LIM_W   = CW'(SPREAD_LIM);
    localparam logic [SUMW-1:0] SPLIT_W = SUMW'(LUMA_SPLIT);
    localparam logic [CW-1:0]   ON_W    = CW'(ON_LEVEL);

    logic       gray, r_on, g_on, b_on;
    logic [1:0] code_d;

    always_comb begin
        gray = spread_q < LIM_W;
        r_on = r_q > ON_W;
        g_on = g_q > ON_W;
        b_on = b_q > ON_W;
        if (gray)
            code_d = (sum_q > SPLIT_W) ? CODE_WHITE : CODE_BLACK;
        else if (r_on)
            code_d = b_on ? CODE_WHITE : (g_on ? CODE_YEL : CODE_RED);
        else
            code_d = (b_on && g_on) ? CODE_WHITE : CODE_BLACK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   code_q <= CODE_BLACK;
        else if (adv) code_q <= code_d;
    end
endmodule

// File: rtl/rgb4_quant.sv
`timescale 1ns/1ps
module rgb4_quant #(
    parameter int         CW         = 8,
    parameter int         SPREAD_LIM = 50,
    parameter int         LUMA_SPLIT = 382,
    parameter int         ON_LEVEL   = 128,
    parameter logic [1:0] CODE_BLACK = 2'b00,
    parameter logic [1:0] CODE_WHITE = 2'b01,
    parameter logic [1:0] CODE_YEL   = 2'b10,
    parameter logic [1:0] CODE_RED   = 2'b11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_r,
    input  logic [CW-1:0] in_g,
    input  logic [CW-1:0] in_b,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [1:0]    out_code
);
    localparam int SUMW = CW + 2;

    logic            adv, s1_v, s2_v;
    logic [CW-1:0]   r_q, g_q, b_q, spread_q;
    logic [SUMW-1:0] sum_q;

    rgb4_flow u_flow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .adv(adv), .s1_v(s1_v), .s2_v(s2_v)
    );

    rgb4_span #(.CW(CW), .SUMW(SUMW)) u_span (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .r(in_r), .g(in_g), .b(in_b),
        .r_q(r_q), .g_q(g_q), .b_q(b_q), .spread_q(spread_q), .sum_q(sum_q)
    );

    rgb4_classify #(
        .CW(CW), .SUMW(SUMW), .SPREAD_LIM(SPREAD_LIM), .LUMA_SPLIT(LUMA_SPLIT),
        .ON_LEVEL(ON_LEVEL), .CODE_BLACK(CODE_BLACK), .CODE_WHITE(CODE_WHITE),
        .CODE_YEL(CODE_YEL), .CODE_RED(CODE_RED)
    ) u_cls (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .r_q(r_q), .g_q(g_q), .b_q(b_q), .spread_q(spread_q), .sum_q(sum_q),
        .code_q(out_code)
    );

    assign in_ready  = adv;
    assign out_valid = s2_v;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

    // R1
    gray_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v && spread_q < CW'(SPREAD_LIM) && sum_q > SUMW'(LUMA_SPLIT))
        |=> out_code == CODE_WHITE);

    // R1
    gray_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v && spread_q < CW'(SPREAD_LIM) && sum_q <= SUMW'(LUMA_SPLIT))
        |=> out_code == CODE_BLACK);

    // R3
    yellow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v && spread_q >= CW'(SPREAD_LIM) && r_q > CW'(ON_LEVEL)
         && g_q > CW'(ON_LEVEL) && b_q <= CW'(ON_LEVEL))
        |=> out_code == CODE_YEL);

    // R4
    magenta_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && s1_v && spread_q >= CW'(SPREAD_LIM) && r_q > CW'(ON_LEVEL)
         && b_q > CW'(ON_LEVEL))
        |=> out_code == CODE_WHITE);
endmodule

// File: tb/test_rgb4_quant.sv
`timescale 1ns/1ps
module test_rgb4_quant;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_r = '0, in_g = '0, in_b = '0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [1:0] out_code;

    int n_chk = 0, n_fail = 0;
    int wp = 0, rp = 0;
    logic [1:0] exp_c [0:1023];
    int         exp_t [0:1023];
    bit  bp_en = 1'b0;
    bit  stall_pend = 1'b0;
    logic [1:0] stall_code = '0;

    always #2.5 clk = ~clk;

    rgb4_quant i_rgb4_quant (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference: returns code (R6 default map) and the rule that decided it
    function automatic logic [1:0] ref_code(input int r, input int g, input int b, output int tag);
        int hi = (r > g) ? r : g;
        int lo = (r < g) ? r : g;
        hi = (hi > b) ? hi : b;
        lo = (lo < b) ? lo : b;
        if (hi - lo < 50) begin tag = 1; return (r + g + b > 382) ? 2'b01 : 2'b00; end
        if (r > 128) begin
            if (b > 128) begin tag = 4; return 2'b01; end
            tag = 3; return (g > 128) ? 2'b10 : 2'b11;
        end
        tag = 5;
        return (g > 128 && b > 128) ? 2'b01 : 2'b00;
    endfunction

    function automatic string tag_name(input int t);
        case (t)
            1: return "R1";
            3: return "R3/R2";
            4: return "R4/R2";
            5: return "R5/R2";
            default: return "R6";
        endcase
    endfunction

    // output monitor, sampled mid-cycle
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (stall_pend) begin
                chk(out_valid && out_code == stall_code, "R8 hold", int'(out_code), int'(stall_code));
                stall_pend = 1'b0;
            end
            if (out_valid && out_ready) begin
                if (rp == wp) chk(1'b0, "R9 extra output", rp, wp);
                else begin
                    chk(out_code == exp_c[rp % 1024], tag_name(exp_t[rp % 1024]),
                        int'(out_code), int'(exp_c[rp % 1024]));
                    rp++;
                end
            end
            if (out_valid && !out_ready) begin
                stall_pend = 1'b1;
                stall_code = out_code;
            end
        end
    end

    // consumer ready pattern
    initial forever begin
        @(posedge clk); #1;
        out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;
    end

    // drive one pixel (entered at posedge+1), returns at posedge+1 after acceptance
    task automatic send(input int r, input int g, input int b);
        int t;
        in_r = 8'(r); in_g = 8'(g); in_b = 8'(b);
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        exp_c[wp % 1024] = ref_code(r, g, b, t);
        exp_t[wp % 1024] = t;
        wp++;
        @(posedge clk); #1;
    endtask

    task automatic drain();
        in_valid = 1'b0;
        bp_en = 1'b0;
        repeat (8) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic t_corners();
        int v [6] = '{0, 49, 50, 128, 129, 255};
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 6; k++)
                    send(v[i], v[j], v[k]);
        send(127, 127, 128);  // R1 sum 382 -> black
        send(127, 128, 128);  // R1 sum 383 -> white
        send(128, 80, 128);   // R2 spread 48 gray; then 128 unlit cases below
        send(200, 128, 0);    // R2 green at 128 unlit -> red
        send(200, 129, 0);    // R3 yellow
        drain();
    endtask

    task automatic t_random(input bit backpressure);
        bp_en = backpressure;
        for (int i = 0; i < 300; i++)
            send($urandom % 256, $urandom % 256, $urandom % 256);
        drain();
    endtask

    task automatic t_latency();
        int t;
        drain();
        in_r = 8'd255; in_g = 8'd0; in_b = 8'd0;
        exp_c[wp % 1024] = ref_code(255, 0, 0, t);
        exp_t[wp % 1024] = t;
        wp++;
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 cycle n", int'(out_valid), 0);
        @(posedge clk); #1 in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7 cycle n+1", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 cycle n+2", int'(out_valid), 1);
        drain();
    endtask

    task automatic t_ready_rule();
        bp_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            in_valid = 1'b1;
            @(negedge clk);
            chk(in_ready == (!out_valid || out_ready), "R8 in_ready",
                int'(in_ready), int'(!out_valid || out_ready));
            if (in_ready) begin
                int t;
                exp_c[wp % 1024] = ref_code(in_r, in_g, in_b, t);
                exp_t[wp % 1024] = t;
                wp++;
            end
            @(posedge clk); #1;
            in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
        end
        drain();
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_corners();
        t_latency();
        t_random(1'b0);
        t_random(1'b1);
        t_ready_rule();
        chk(rp == wp, "R9 count", rp, wp);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule